// File: doc/BRIEF.md
# Nonvolatile Register Store Controller

This block models a small nonvolatile byte store that sits beside a pair of digital wiper registers. It holds sixteen 8-bit locations. Two of them keep a backup code for each wiper and the other fourteen are free for general constants. Commands arrive as a one-cycle strobe that carries an opcode, an address and a data byte.

A save copies a wiper's live code into its backup byte. A user write places the data byte into a general location. Both run a fixed programming time, and `ready` is low for that whole time. A read returns any stored byte. Two restore opcodes send both backup bytes out on the restore bus with a one-cycle valid pulse, for the wiper registers to load. The same transfer happens once, on its own, right after reset.

The storage is modelled as flip-flops with a programming delay. Reset stands for the factory state of the store.

Top module: `nvstore_ctrl`

## Requirements
- R1: Addresses 0 and 1 hold the backup bytes of wiper 0 and wiper 1. Addresses 2 to 15 are user bytes. After reset each backup byte reads 0x80 (midscale) and each user byte reads 0x00.
- R2: In the first cycle after reset is released, `rst_valid` is high for exactly one cycle and `rst_data` is {backup1, backup0}.
- R3: Opcode 2 with address 0 or 1 captures that wiper's byte of `wiper_code` (wiper n at bits 8n+7:8n) when it is accepted. `ready` is then low for exactly PROG_CYCLES cycles, starting in the cycle after acceptance, and the byte is stored when `ready` returns high. Opcode 2 with an address of 2 or more has no effect.
- R4: Opcode 3 with an address from 2 to 15 stores `cmd_data` there, with the same busy period as R3. Opcode 3 with address 0 or 1 has no effect.
- R5: Opcode 9 raises `rd_valid` for one cycle in the cycle after the command, with `rd_data` holding the stored byte at `cmd_addr`. During a busy period, the location being programmed still reads its old value.
- R6: Opcodes 1 and 8 raise `rst_valid` for one cycle in the next cycle, with `rst_data` = {backup1, backup0}. Opcode 1 also sets `read_mode`. Opcode 0 clears it, and no other opcode changes it.
- R7: An opcode 2 or opcode 3 that arrives while `ready` is low is ignored. The stored bytes and the length of the busy period are unchanged.
- R8: While `wp_n` is low, opcodes 2 and 3 are ignored and `ready` stays high. Opcodes 1, 8 and 9 still work.
- R9: A read or restore issued in the last busy cycle returns the byte that is being programmed in that cycle.
- R10: Opcodes 4 to 7 and 10 to 15 have no effect on the store, `ready`, `rst_valid` or `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores factory contents |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W | Store location |
| cmd_data | input | DATA_W | Byte for user writes |
| wp_n | input | 1 | Write protect, active low |
| wiper_code | input | WIPERS*DATA_W | Live wiper codes, captured by a save |
| rst_valid | output | 1 | Restore pulse |
| rst_data | output | WIPERS*DATA_W | Backup bytes for the wipers |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| ready | output | 1 | Low while programming |
| read_mode | output | 1 | Set by opcode 1, cleared by opcode 0 |

## Verification
A program can complete, so that the pending byte enters the store, in the same cycle that a restore or a read samples the store. The bench provokes this by counting to the final busy cycle after a save and after a user write, then issuing a restore and a read in that cycle. It expects the newly programmed byte on `rst_data` and `rd_data`, not the old one. Reads earlier in the busy period are expected to return the old byte, which shows that the two cases are told apart.

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int WIPERS      = 2,
  parameter int PROG_CYCLES = 100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [3:0]               cmd_op,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [DATA_W-1:0]        cmd_data,
  input  logic                     wp_n,
  input  logic [WIPERS*DATA_W-1:0] wiper_code,
  output logic                     rst_valid,
  output logic [WIPERS*DATA_W-1:0] rst_data,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     ready,
  output logic                     read_mode
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);
  localparam int WSEL_W = (WIPERS > 1) ? $clog2(WIPERS) : 1;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));
  localparam logic [3:0] OP_NOP = 4'd0, OP_RST_RD = 4'd1, OP_SAVE = 4'd2,
                         OP_UWR = 4'd3, OP_RST = 4'd8, OP_READ = 4'd9;

  logic [DEPTH*DATA_W-1:0] mem, mem_view;
  logic                    busy, pu_done;
  logic [CNT_W-1:0]        cnt;
  logic [ADDR_W-1:0]       pend_addr;
  logic [DATA_W-1:0]       pend_data;

  wire commit   = busy && (cnt == '0);
  wire wr_op    = cmd_valid && (cmd_op == OP_SAVE || cmd_op == OP_UWR);
  wire is_save  = cmd_valid && cmd_op == OP_SAVE && wp_n && !busy && int'(cmd_addr) < WIPERS;
  wire is_uwr   = cmd_valid && cmd_op == OP_UWR  && wp_n && !busy && int'(cmd_addr) >= WIPERS;
  wire do_rest  = cmd_valid && (cmd_op == OP_RST_RD || cmd_op == OP_RST);
  wire do_read  = cmd_valid && cmd_op == OP_READ;
  wire send_rst = do_rest || !pu_done;

  assign ready = !busy;

  always_comb begin
    mem_view = mem;
    if (commit) mem_view[pend_addr*DATA_W +: DATA_W] = pend_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i*DATA_W +: DATA_W] <= (i < WIPERS) ? MID : '0;
      busy      <= 1'b0;
      cnt       <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      mem <= mem_view;
      if (is_save || is_uwr) begin
        busy      <= 1'b1;
        cnt       <= CNT_W'(PROG_CYCLES - 1);
        pend_addr <= cmd_addr;
        pend_data <= is_save ? wiper_code[cmd_addr[WSEL_W-1:0]*DATA_W +: DATA_W] : cmd_data;
      end else if (busy) begin
        if (commit) busy <= 1'b0;
        else        cnt  <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_done   <= 1'b0;
      rst_valid <= 1'b0;
      rst_data  <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      read_mode <= 1'b0;
    end else begin
      pu_done   <= 1'b1;
      rst_valid <= send_rst;
      if (send_rst) rst_data <= mem_view[WIPERS*DATA_W-1:0];
      rd_valid  <= do_read;
      if (do_read) rd_data <= mem_view[cmd_addr*DATA_W +: DATA_W];
      if (cmd_valid && cmd_op == OP_RST_RD)   read_mode <= 1'b1;
      else if (cmd_valid && cmd_op == OP_NOP) read_mode <= 1'b0;
    end
  end

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit && wr_op) |=> (!ready && $stable(pend_addr) && $stable(pend_data)));
  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && ready && wr_op) |=> ready);
  // R3
  prog_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ready);
  // R6
  restore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_rest |=> rst_valid);
  // R6
  nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_NOP) |=> !read_mode);
  // R5
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_read |=> rd_valid);
endmodule

// File: tb/nvstore_ctrl_tb_top.sv
module nvstore_ctrl_tb_top;
  localparam int PROG = 12;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, wp_n = 1'b1;
  logic [3:0] cmd_op = '0, cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [15:0] wiper_code = 16'h3CA5;
  logic rst_valid, rd_valid, ready, read_mode;
  logic [15:0] rst_data;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  nvstore_ctrl #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .wiper_code(wiper_code),
    .rst_valid(rst_valid), .rst_data(rst_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .ready(ready), .read_mode(read_mode));

  // {op, addr, data, check addr, expected}
  localparam logic [27:0] VEC [7] = '{
    {4'd3, 4'd2,  8'h5A, 4'd2,  8'h5A},   // R4
    {4'd3, 4'd15, 8'hC3, 4'd15, 8'hC3},   // R4
    {4'd3, 4'd0,  8'h77, 4'd0,  8'h80},   // R4 backup not user-writable
    {4'd2, 4'd0,  8'h00, 4'd0,  8'hA5},   // R3
    {4'd2, 4'd1,  8'h00, 4'd1,  8'h3C},   // R3
    {4'd2, 4'd7,  8'h00, 4'd7,  8'h00},   // R3 bad address
    {4'd9, 4'd2,  8'h00, 4'd2,  8'h5A}    // R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [3:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic read_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    drive(4'd9, a, 8'h00);
    check(tag, {rd_valid, rd_data}, {1'b1, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 powerup pulse", {rst_valid, rst_data}, {1'b1, 16'h8080});
    check("R2 ready/read_mode after reset", {ready, read_mode}, 2'b10);
    @(negedge clk);
    check("R2 pulse one cycle", rst_valid, 1'b0);
    read_chk("R1 backup0 midscale", 4'd0, 8'h80);
    read_chk("R1 backup1 midscale", 4'd1, 8'h80);
    read_chk("R1 user zero", 4'd14, 8'h00);

    for (int i = 0; i < 7; i++) begin
      drive(VEC[i][27:24], VEC[i][23:20], VEC[i][19:12]);
      wait_ready();
      read_chk($sformatf("R3/R4/R5 vector %0d", i), VEC[i][11:8], VEC[i][7:0]);
    end

    drive(4'd8, 4'd0, 8'h00);
    check("R6 restore op8", {rst_valid, rst_data, read_mode}, {1'b1, 16'h3CA5, 1'b0});
    drive(4'd1, 4'd0, 8'h00);
    check("R6 restore op1", {rst_valid, rst_data, read_mode}, {1'b1, 16'h3CA5, 1'b1});
    read_chk("R6 read keeps read_mode data", 4'd2, 8'h5A);
    check("R6 read keeps read_mode", read_mode, 1'b1);
    drive(4'd0, 4'd0, 8'h00);
    check("R6 nop clears read_mode", read_mode, 1'b0);

    drive(4'd2, 4'd0, 8'h00);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    check("R3 busy length", n, PROG);

    drive(4'd3, 4'd5, 8'h11);
    drive(4'd3, 4'd5, 8'h22);
    n = 1;
    while (!ready) begin n++; @(negedge clk); end
    check("R7 busy not extended", n, PROG);
    read_chk("R7 write while busy ignored", 4'd5, 8'h11);

    wp_n = 1'b0;
    drive(4'd3, 4'd2, 8'h99);
    check("R8 user write blocked ready", ready, 1'b1);
    wiper_code = 16'h3C10;
    drive(4'd2, 4'd0, 8'h00);
    check("R8 save blocked ready", ready, 1'b1);
    read_chk("R8 user byte kept", 4'd2, 8'h5A);
    read_chk("R8 backup kept", 4'd0, 8'hA5);
    drive(4'd8, 4'd0, 8'h00);
    check("R8 restore works", {rst_valid, rst_data}, {1'b1, 16'h3CA5});
    wp_n = 1'b1;

    drive(4'd4, 4'd0, 8'h00);
    check("R10 unused op", {ready, rst_valid, rd_valid}, 3'b100);
    drive(4'd12, 4'd3, 8'hEE);
    check("R10 unused op 12", {ready, rst_valid, rd_valid}, 3'b100);
    read_chk("R10 store unchanged", 4'd3, 8'h00);

    wiper_code = 16'h4410;
    drive(4'd2, 4'd1, 8'h00);
    read_chk("R5 old value while busy", 4'd1, 8'h3C);
    wait_ready();
    read_chk("R5 new value after busy", 4'd1, 8'h44);

    wiper_code = 16'h44E1;
    drive(4'd2, 4'd0, 8'h00);
    repeat (PROG - 1) @(negedge clk);
    drive(4'd8, 4'd0, 8'h00);
    check("R9 restore in commit cycle", {rst_valid, rst_data, ready}, {1'b1, 16'h44E1, 1'b1});

    drive(4'd3, 4'd9, 8'hD4);
    repeat (PROG - 1) @(negedge clk);
    read_chk("R9 read in commit cycle", 4'd9, 8'hD4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule